// File: doc/BRIEF.md
# Junction Signal Sequencer with Crosswalk

This block sequences the lamps of a two-road junction that also carries a pedestrian crossing. One timed state machine owns all three lamp groups, so the main road, the side road and the crosswalk can never be driven from separate and disagreeing controllers. The fast system clock is divided down inside the block into a single-cycle enable pulse, once per second by default. Every phase timer counts these pulses.

A full cycle gives the main road its green and then its yellow, and does the same for the side road. The walk lamp then turns green. After that the walk red lamp flashes as a warning, and then the three red lamps flash together before the cycle returns to main green. Flashing lamps change state on every enable pulse, and each flashing phase begins with the lamp on. All phase lengths and the clock divide value are parameters, so a simulation can run with a short divide. The lamp outputs are decoded combinationally from registered state.

Top module: `jss_junction_top`

## Requirements
- R1: While `rst` is high at a clock edge, the controller enters the main-green phase with its timers and prescaler cleared. The outputs then show main green, side red and walk red.
- R2: The enable pulse is high for one system clock out of every `TICK_DIV`. The phase can change only at the clock edge that follows an enable pulse. After reset, phase boundaries therefore fall on edge numbers that are multiples of `TICK_DIV`.
- R3: The phases follow this order: main green, main yellow, side green, side yellow, walk green, walk-red flash, all-red flash.
- R4: Each phase lasts exactly its parameter number of enable pulses. The defaults are 10, 3, 8, 3, 6, 4 and 2, in the order of R3. The timer restarts whenever the phase changes.
- R5: In the walk-red flash phase, both road groups hold steady red and the walk green lamp is off. The walk red lamp is on for the first enable interval and toggles on every later pulse.
- R6: In the all-red flash phase, the main, side and walk red lamps are lit together and all other lamps are off. The three red lamps start on and toggle together on every enable pulse.
- R7: When the all-red flash phase ends, the controller returns to main green and repeats the cycle with the same timing.
- R8: Each group lights at most one lamp at a time. A road shows green or yellow only while the other road and the walk group both show red. The walk green lamp lights only while both roads show red.
- R9: Lamp encoding: a road group uses bit 2 for red, bit 1 for yellow and bit 0 for green. The walk group uses bit 1 for red and bit 0 for green.
- R10: Asserting reset in the middle of any phase restarts the whole sequence from the main-green phase with full timing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock (nominally 100 MHz) |
| rst | input | 1 | Synchronous reset, active high |
| main_lamps | output | 3 | Main road lamps {red, yellow, green} |
| side_lamps | output | 3 | Side road lamps {red, yellow, green} |
| walk_lamps | output | 2 | Crosswalk lamps {red, green} |

## Verification
The hardest cases to reach from the ports lie at the end of the cycle. These are the toggling of the flashing phases, the all-red flash phase itself, and the wrap back to main green. With the default divide, reaching them takes billions of clocks. The bench therefore sets the divide to four, so the whole 36-pulse cycle takes 144 clocks. It compares every output against an arithmetic model on every clock across two full cycles. It then resets in the middle of a phase and follows the restarted sequence.

// File: rtl/jss_pkg.sv
package jss_pkg;

    typedef enum logic [2:0] {
        PH_MAIN_GO    = 3'd0,
        PH_MAIN_WARN  = 3'd1,
        PH_SIDE_GO    = 3'd2,
        PH_SIDE_WARN  = 3'd3,
        PH_WALK_GO    = 3'd4,
        PH_WALK_FLASH = 3'd5,
        PH_ALL_FLASH  = 3'd6
    } phase_e;

    // Road lamp codes: bit2 red, bit1 yellow, bit0 green
    localparam logic [2:0] ROAD_RED    = 3'b100;
    localparam logic [2:0] ROAD_YELLOW = 3'b010;
    localparam logic [2:0] ROAD_GREEN  = 3'b001;
    localparam logic [2:0] ROAD_DARK   = 3'b000;
    // Walk lamp codes: bit1 red, bit0 green
    localparam logic [1:0] WALK_RED    = 2'b10;
    localparam logic [1:0] WALK_GREEN  = 2'b01;
    localparam logic [1:0] WALK_DARK   = 2'b00;

    function automatic phase_e phase_after(input phase_e cur);
        case (cur)
            PH_MAIN_GO:    phase_after = PH_MAIN_WARN;
            PH_MAIN_WARN:  phase_after = PH_SIDE_GO;
            PH_SIDE_GO:    phase_after = PH_SIDE_WARN;
            PH_SIDE_WARN:  phase_after = PH_WALK_GO;
            PH_WALK_GO:    phase_after = PH_WALK_FLASH;
            PH_WALK_FLASH: phase_after = PH_ALL_FLASH;
            default:       phase_after = PH_MAIN_GO;
        endcase
    endfunction

    function automatic int larger(input int a, input int b);
        larger = (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/jss_tick_gen.sv
module jss_tick_gen #(
    parameter int TICK_DIV = 100_000_000
) (
    input  logic clk,
    input  logic rst,
    output logic tick_o
);
    localparam int CW = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } div_s;

    div_s div_d, div_q;
    logic at_last;

    always_comb begin
        div_d   = div_q;
        at_last = (div_q.cnt == LAST);
        if (at_last) begin
            div_d.cnt = '0;
        end else begin
            div_d.cnt = div_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q <= '0;
        end else begin
            div_q <= div_d;
        end
    end

    assign tick_o = at_last;

endmodule

// File: rtl/jss_phase_fsm.sv
module jss_phase_fsm
    import jss_pkg::*;
#(
    parameter int MAIN_GO_S    = 10,
    parameter int MAIN_WARN_S  = 3,
    parameter int SIDE_GO_S    = 8,
    parameter int SIDE_WARN_S  = 3,
    parameter int WALK_GO_S    = 6,
    parameter int WALK_FLASH_S = 4,
    parameter int ALL_FLASH_S  = 2
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   tick_i,
    output phase_e phase_o,
    output logic   blink_on_o
);
    localparam int DUR_MAX = larger(larger(larger(MAIN_GO_S, MAIN_WARN_S),
                                           larger(SIDE_GO_S, SIDE_WARN_S)),
                                    larger(larger(WALK_GO_S, WALK_FLASH_S),
                                           ALL_FLASH_S));
    localparam int TW = $clog2(DUR_MAX + 1);

    typedef struct packed {
        phase_e        phase;
        logic [TW-1:0] timer;
        logic          blink;
    } fsm_s;

    fsm_s fsm_d, fsm_q;
    logic [TW-1:0] last_count;

    function automatic int span_of(input phase_e ph);
        case (ph)
            PH_MAIN_GO:    span_of = MAIN_GO_S;
            PH_MAIN_WARN:  span_of = MAIN_WARN_S;
            PH_SIDE_GO:    span_of = SIDE_GO_S;
            PH_SIDE_WARN:  span_of = SIDE_WARN_S;
            PH_WALK_GO:    span_of = WALK_GO_S;
            PH_WALK_FLASH: span_of = WALK_FLASH_S;
            default:       span_of = ALL_FLASH_S;
        endcase
    endfunction

    always_comb begin
        fsm_d      = fsm_q;
        last_count = TW'(span_of(fsm_q.phase) - 1);
        if (tick_i) begin
            if (fsm_q.timer == last_count) begin
                fsm_d.phase = phase_after(fsm_q.phase);
                fsm_d.timer = '0;
                fsm_d.blink = 1'b1;
            end else begin
                fsm_d.timer = fsm_q.timer + 1'b1;
                fsm_d.blink = ~fsm_q.blink;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fsm_q.phase <= PH_MAIN_GO;
            fsm_q.timer <= '0;
            fsm_q.blink <= 1'b1;
        end else begin
            fsm_q <= fsm_d;
        end
    end

    assign phase_o    = fsm_q.phase;
    assign blink_on_o = fsm_q.blink;

endmodule

// File: rtl/jss_lamp_decode.sv
module jss_lamp_decode
    import jss_pkg::*;
(
    input  phase_e     phase_i,
    input  logic       blink_on_i,
    output logic [2:0] main_o,
    output logic [2:0] side_o,
    output logic [1:0] walk_o
);
    always_comb begin
        main_o = ROAD_RED;
        side_o = ROAD_RED;
        walk_o = WALK_RED;
        case (phase_i)
            PH_MAIN_GO:    main_o = ROAD_GREEN;
            PH_MAIN_WARN:  main_o = ROAD_YELLOW;
            PH_SIDE_GO:    side_o = ROAD_GREEN;
            PH_SIDE_WARN:  side_o = ROAD_YELLOW;
            PH_WALK_GO:    walk_o = WALK_GREEN;
            PH_WALK_FLASH: walk_o = blink_on_i ? WALK_RED : WALK_DARK;
            PH_ALL_FLASH: begin
                main_o = blink_on_i ? ROAD_RED : ROAD_DARK;
                side_o = blink_on_i ? ROAD_RED : ROAD_DARK;
                walk_o = blink_on_i ? WALK_RED : WALK_DARK;
            end
            default: begin
                main_o = ROAD_RED;
                side_o = ROAD_RED;
                walk_o = WALK_RED;
            end
        endcase
    end

endmodule

// File: rtl/jss_junction_top.sv
module jss_junction_top
    import jss_pkg::*;
#(
    parameter int TICK_DIV     = 100_000_000,
    parameter int MAIN_GO_S    = 10,
    parameter int MAIN_WARN_S  = 3,
    parameter int SIDE_GO_S    = 8,
    parameter int SIDE_WARN_S  = 3,
    parameter int WALK_GO_S    = 6,
    parameter int WALK_FLASH_S = 4,
    parameter int ALL_FLASH_S  = 2
) (
    input  logic       clk,
    input  logic       rst,
    output logic [2:0] main_lamps,
    output logic [2:0] side_lamps,
    output logic [1:0] walk_lamps
);
    logic   tick_w;
    phase_e phase_w;
    logic   blink_w;

    jss_tick_gen #(
        .TICK_DIV(TICK_DIV)
    ) u_tick (
        .clk   (clk),
        .rst   (rst),
        .tick_o(tick_w)
    );

    jss_phase_fsm #(
        .MAIN_GO_S   (MAIN_GO_S),
        .MAIN_WARN_S (MAIN_WARN_S),
        .SIDE_GO_S   (SIDE_GO_S),
        .SIDE_WARN_S (SIDE_WARN_S),
        .WALK_GO_S   (WALK_GO_S),
        .WALK_FLASH_S(WALK_FLASH_S),
        .ALL_FLASH_S (ALL_FLASH_S)
    ) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .tick_i    (tick_w),
        .phase_o   (phase_w),
        .blink_on_o(blink_w)
    );

    jss_lamp_decode u_dec (
        .phase_i   (phase_w),
        .blink_on_i(blink_w),
        .main_o    (main_lamps),
        .side_o    (side_lamps),
        .walk_o    (walk_lamps)
    );

endmodule

// File: rtl/jss_checker.sv
module jss_checker
    import jss_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       tick,
    input phase_e     phase,
    input logic [2:0] main_lamps,
    input logic [2:0] side_lamps,
    input logic [1:0] walk_lamps
);
    assert_one_lamp_R8: assert property (@(posedge clk) disable iff (rst)
        $onehot0(main_lamps) && $onehot0(side_lamps) && $onehot0(walk_lamps));

    assert_main_go_safe_R8: assert property (@(posedge clk) disable iff (rst)
        (main_lamps[1] || main_lamps[0]) |-> (side_lamps == ROAD_RED && walk_lamps == WALK_RED));

    assert_side_go_safe_R8: assert property (@(posedge clk) disable iff (rst)
        (side_lamps[1] || side_lamps[0]) |-> (main_lamps == ROAD_RED && walk_lamps == WALK_RED));

    assert_walk_go_safe_R8: assert property (@(posedge clk) disable iff (rst)
        walk_lamps[0] |-> (main_lamps == ROAD_RED && side_lamps == ROAD_RED));

    assert_hold_between_ticks_R2: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(phase));

    assert_reset_entry_R1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (main_lamps == ROAD_GREEN && side_lamps == ROAD_RED && walk_lamps == WALK_RED));

    assert_order_main_R3: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_MAIN_GO) |=> (phase == PH_MAIN_GO || phase == PH_MAIN_WARN));

    assert_order_walk_R3: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_WALK_GO) |=> (phase == PH_WALK_GO || phase == PH_WALK_FLASH));

    assert_wrap_R7: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_ALL_FLASH) |=> (phase == PH_ALL_FLASH || phase == PH_MAIN_GO));

    assert_reds_together_R6: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_ALL_FLASH) |-> (main_lamps[2] == side_lamps[2] && side_lamps[2] == walk_lamps[1]));

    assert_flash_entry_on_R5: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_WALK_FLASH && $past(phase) == PH_WALK_GO) |-> (walk_lamps == WALK_RED));

endmodule

bind jss_junction_top jss_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick_w),
    .phase     (phase_w),
    .main_lamps(main_lamps),
    .side_lamps(side_lamps),
    .walk_lamps(walk_lamps)
);

// File: tb/sim_jss_junction_top.sv
`timescale 1ns/1ps
module sim_jss_junction_top;
    localparam int DIV   = 4;
    localparam int NPH   = 7;
    localparam int D0 = 10, D1 = 3, D2 = 8, D3 = 3, D4 = 6, D5 = 4, D6 = 2;
    localparam int CYCLE = D0 + D1 + D2 + D3 + D4 + D5 + D6;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] main_lamps, side_lamps;
    logic [1:0] walk_lamps;

    int errors = 0;
    int checks = 0;

    always #2.5 clk = ~clk;

    jss_junction_top #(
        .TICK_DIV(DIV), .MAIN_GO_S(D0), .MAIN_WARN_S(D1), .SIDE_GO_S(D2),
        .SIDE_WARN_S(D3), .WALK_GO_S(D4), .WALK_FLASH_S(D5), .ALL_FLASH_S(D6)
    ) u0 (
        .clk(clk), .rst(rst),
        .main_lamps(main_lamps), .side_lamps(side_lamps), .walk_lamps(walk_lamps)
    );

    function automatic int dur(input int ph);
        case (ph)
            0: dur = D0; 1: dur = D1; 2: dur = D2; 3: dur = D3;
            4: dur = D4; 5: dur = D5; default: dur = D6;
        endcase
    endfunction

    // expected lamps {main, side, walk} after edge e since reset release
    function automatic logic [7:0] model(input int e, output int ph, output int off);
        int t;
        logic on;
        logic [2:0] m, s;
        logic [1:0] w;
        t   = (e / DIV) % CYCLE;
        ph  = 0;
        off = t;
        while (off >= dur(ph)) begin
            off = off - dur(ph);
            ph  = ph + 1;
        end
        on = ((off % 2) == 0);
        m = 3'b100; s = 3'b100; w = 2'b10;
        case (ph)
            0: m = 3'b001;
            1: m = 3'b010;
            2: s = 3'b001;
            3: s = 3'b010;
            4: w = 2'b01;
            5: w = on ? 2'b10 : 2'b00;
            default: begin
                m = on ? 3'b100 : 3'b000;
                s = on ? 3'b100 : 3'b000;
                w = on ? 2'b10 : 2'b00;
            end
        endcase
        model = {m, s, w};
    endfunction

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: lamps got %b expected %b at %0t", req, got, exp, $time);
        end
    endtask

    task automatic check_safety();
        logic ok;
        ok = $onehot0(main_lamps) && $onehot0(side_lamps) && $onehot0(walk_lamps);
        if (main_lamps[1] || main_lamps[0]) ok = ok && side_lamps == 3'b100 && walk_lamps == 2'b10;
        if (side_lamps[1] || side_lamps[0]) ok = ok && main_lamps == 3'b100 && walk_lamps == 2'b10;
        if (walk_lamps[0]) ok = ok && main_lamps == 3'b100 && side_lamps == 3'b100;
        check("R8", {7'b0, ok}, 8'd1);
    endtask

    task automatic run_span(input int edges, input bool_tag);
    endtask

    initial begin
        int ph, off;
        logic [7:0] exp;
        string tag;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 / R9: reset state, main green 001, side red 100, walk red 10
        check("R1", {main_lamps, side_lamps, walk_lamps}, 8'b001_100_10);
        check("R9", {main_lamps, side_lamps, walk_lamps}, {3'b001, 3'b100, 2'b10});
        rst = 1'b0;
        for (int e = 1; e <= 2 * CYCLE * DIV; e++) begin
            @(negedge clk);
            exp = model(e, ph, off);
            if (ph == 5)                          tag = "R5";
            else if (ph == 6)                     tag = "R6";
            else if (e >= CYCLE * DIV)            tag = "R7";
            else if (off == 0 && e % DIV == 0)    tag = "R4";
            else if (e % DIV != 0)                tag = "R2";
            else                                  tag = "R3";
            check(tag, {main_lamps, side_lamps, walk_lamps}, exp);
            check_safety();
        end
        // advance into side green, then reset mid-phase
        for (int e = 1; e <= (D0 + D1 + 2) * DIV + 1; e++) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        check("R10", {main_lamps, side_lamps, walk_lamps}, 8'b001_100_10);
        for (int e = 1; e <= (D0 + D1 + D2 + 1) * DIV; e++) begin
            @(negedge clk);
            exp = model(e, ph, off);
            check("R10", {main_lamps, side_lamps, walk_lamps}, exp);
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: run did not finish, got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule